// File: doc/BRIEF.md
# Parallel EPROM Mode Decoder Model

This block is a clocked, synthesizable stand-in for a byte-wide UV-erasable / one-time-programmable memory. It is intended to sit opposite a device programmer under test. It takes the usual active-low chip and output enables, plus two flags. One says the programming supply is at its high level. The other says the A9 pin is raised to the signature voltage. From these it decides which of seven behaviours applies: read, output disable, standby, program, program verify, program inhibit and identifier readout. The data bus is modelled as a value plus a drive-enable flag. Routing these into a tri-state pad is left to the surrounding fabric.

Programming follows the physics of floating-gate cells: a write can only pull bits from 1 to 0. The stored byte is the old byte ANDed with the bus value. Only a full erase restores ones. The erase is a sweep that visits one location per clock, with a busy flag raised for the whole sweep. A fault-injection input can pin one bit of one address at 1. This lets a programmer's retry and give-up logic be exercised. The external address is 15 bits, but the storage depth is a parameter. Upper address bits alias onto the stored range, which keeps elaboration small.

Top module: `eprom_model`

## Requirements
- R1: With vppHi=0, a9Hi=0, ceN=0 and oeN=0 (read), dataOe is 1 and dataOut equals the byte stored at the addressed location.
- R2: With vppHi=0, output is disabled (dataOe=0) when ceN=1 (standby) or when oeN=1 (output disable).
- R3: With vppHi=1 and oeN=1, a high-to-low transition of ceN (ceN seen 1 at one rising clock edge and 0 at the next) performs exactly one write at that second edge. Holding ceN low does not write again, even if dataIn changes.
- R4: With vppHi=1, ceN=1 and oeN=0 (program verify), dataOe is 1 and dataOut is the stored byte.
- R5: With vppHi=1, the combinations ceN=1/oeN=1 (inhibit) and ceN=0/oeN=0 leave dataOe at 0 and write nothing.
- R6: A write stores old AND dataIn, so a bit already at 0 stays at 0.
- R7: With a9Hi=1, vppHi=0, ceN=0 and oeN=0, dataOut is 0x97 when addr[0]=0 and 0x04 when addr[0]=1, whatever the other address bits are. With ceN or oeN high, dataOe is 0.
- R8: A one-cycle eraseReq while idle raises busy from the next clock for exactly 2^STORE_AW clocks and leaves every location at 0xFF. While busy, dataOe is 0, program pulses have no effect, and eraseReq is ignored.
- R9: After reset, busy is 0 and every location reads 0xFF.
- R10: When faultEn=1 and addr equals faultAddr, a write leaves bit faultBit of that location unchanged. Writes to other addresses are unaffected.
- R11: Only the low STORE_AW address bits (default 10, 1024 bytes) select a location. Higher bits are ignored by both read and program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset; fills storage with ones |
| ceN | input | 1 | Active-low chip enable; its falling edge is the program pulse |
| oeN | input | 1 | Active-low output enable |
| vppHi | input | 1 | Programming supply is at its high level |
| a9Hi | input | 1 | A9 raised to the identifier voltage |
| addr | input | 15 | Byte address |
| dataIn | input | 8 | Bus value presented by the programmer |
| dataOut | output | 8 | Value the model drives onto the bus (0 when not driving) |
| dataOe | output | 1 | Model drives the bus |
| eraseReq | input | 1 | Start an erase sweep |
| busy | output | 1 | Erase sweep in progress |
| faultEn | input | 1 | Enable the stuck-at-1 fault |
| faultAddr | input | 15 | Address where the fault applies |
| faultBit | input | 3 | Bit index held at 1 |

## Verification
A corrupted mode decode shows at dataOe or dataOut as soon as the inputs settle, with no clock delay, because the output path is combinational from the enables and the stored byte. A wrong write, whether a missed edge, a doubled write, a lost AND, or a misapplied fault mask, stays hidden until the location is read back. For that reason every program step in the bench is followed by a read or verify of the same byte. An erase-sequencer fault shows as a wrong busy length, visible the clock after the sweep should end, or as a non-0xFF byte found on a later read.

// File: rtl/eprom_model_pkg.sv
package eprom_model_pkg;

  typedef enum logic [2:0] {
    MD_READ,
    MD_OUTDIS,
    MD_STANDBY,
    MD_PROG,
    MD_VERIFY,
    MD_INHIBIT,
    MD_IDENT,
    MD_ERASE
  } modeT;

  // strobes from control to datapath
  typedef struct packed {
    logic progWr;   // one write of the programming bus
    logic eraseWr;  // write ones at the sweep index
    logic driveMem; // drive stored byte
    logic driveId;  // drive identifier byte
    logic idSel;    // 0: maker byte, 1: part byte
  } strobeT;

endpackage

// File: rtl/eprom_model_ctrl.sv
module eprom_model_ctrl
  import eprom_model_pkg::*;
#(
  parameter int STORE_AW = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ceN,
  input  logic                oeN,
  input  logic                vppHi,
  input  logic                a9Hi,
  input  logic                addrLsb,
  input  logic                eraseReq,
  output strobeT              strobe,
  output logic [STORE_AW-1:0] eraseIdx,
  output logic                busy
);

  localparam int DEPTH = 1 << STORE_AW;
  localparam logic [STORE_AW-1:0] LAST_IDX = STORE_AW'(DEPTH - 1);

  modeT mode;
  logic ceNPrev;
  logic ceFall;

  // enable edge tracking
  always_ff @(posedge clk) begin
    if (!rstN) ceNPrev <= 1'b1;
    else       ceNPrev <= ceN;
  end

  assign ceFall = ceNPrev & ~ceN;

  // mode decode: sweep first, then supply flag, then identifier voltage
  always_comb begin
    mode = MD_STANDBY;
    if (busy) begin
      mode = MD_ERASE;
    end else if (vppHi) begin
      unique case ({ceN, oeN})
        2'b01:   mode = MD_PROG;
        2'b10:   mode = MD_VERIFY;
        2'b11:   mode = MD_INHIBIT;
        default: mode = MD_OUTDIS;
      endcase
    end else if (ceN) begin
      mode = MD_STANDBY;
    end else if (oeN) begin
      mode = MD_OUTDIS;
    end else if (a9Hi) begin
      mode = MD_IDENT;
    end else begin
      mode = MD_READ;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.progWr   = (mode == MD_PROG) && ceFall;
    strobe.eraseWr  = busy;
    strobe.driveMem = (mode == MD_READ) || (mode == MD_VERIFY);
    strobe.driveId  = (mode == MD_IDENT);
    strobe.idSel    = addrLsb;
  end

  // erase sweep
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      eraseIdx <= '0;
    end else if (busy) begin
      if (eraseIdx == LAST_IDX) begin
        busy     <= 1'b0;
        eraseIdx <= '0;
      end else begin
        eraseIdx <= eraseIdx + 1'b1;
      end
    end else if (eraseReq) begin
      busy     <= 1'b1;
      eraseIdx <= '0;
    end
  end

  // checker: length of each busy run
  logic [STORE_AW-1:0] runLen;
  always_ff @(posedge clk) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else           runLen <= '0;
  end

  // R3: a held-low enable never yields two writes in a row
  assert_single_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.progWr |=> !strobe.progWr);

  // R5: no write unless supply high and output enable high
  assert_inhibit_no_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.progWr |-> (vppHi && oeN && !ceN && !busy));

  // R8: a sweep lasts exactly DEPTH clocks
  assert_erase_length_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(runLen) == LAST_IDX));

endmodule

// File: rtl/eprom_model_array.sv
module eprom_model_array
  import eprom_model_pkg::*;
#(
  parameter int              ADDR_W   = 15,
  parameter int              DATA_W   = 8,
  parameter int              STORE_AW = 10,
  parameter logic [DATA_W-1:0] MAKER_ID = 8'h97,
  parameter logic [DATA_W-1:0] PART_ID  = 8'h04
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobeT                     strobe,
  input  logic [STORE_AW-1:0]        eraseIdx,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          dataIn,
  input  logic                       faultEn,
  input  logic [ADDR_W-1:0]          faultAddr,
  input  logic [$clog2(DATA_W)-1:0]  faultBit,
  output logic [DATA_W-1:0]          dataOut,
  output logic                       dataOe
);

  localparam int DEPTH = 1 << STORE_AW;
  localparam int BIT_W = $clog2(DATA_W);

  logic [DATA_W-1:0]   mem [DEPTH];
  logic [STORE_AW-1:0] cellIdx;
  logic                faultHit;
  logic [DATA_W-1:0]   keepMask;
  logic [DATA_W-1:0]   writeVal;

  assign cellIdx  = addr[STORE_AW-1:0];
  assign faultHit = faultEn && (addr == faultAddr);
  assign keepMask = faultHit ? (DATA_W'(1) << faultBit) : '0;
  assign writeVal = mem[cellIdx] & (dataIn | keepMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strobe.eraseWr) begin
      mem[eraseIdx] <= '1;
    end else if (strobe.progWr) begin
      mem[cellIdx] <= writeVal;
    end
  end

  always_comb begin
    dataOut = '0;
    if (strobe.driveId)       dataOut = strobe.idSel ? PART_ID : MAKER_ID;
    else if (strobe.driveMem) dataOut = mem[cellIdx];
  end
  assign dataOe = strobe.driveId | strobe.driveMem;

  // checker: remember the cell and its prior value across each write
  logic                chkValid;
  logic                chkStuck;
  logic [STORE_AW-1:0] chkIdx;
  logic [DATA_W-1:0]   chkOld;
  logic [BIT_W-1:0]    chkBit;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkValid <= 1'b0;
      chkStuck <= 1'b0;
      chkIdx   <= '0;
      chkOld   <= '0;
      chkBit   <= '0;
    end else begin
      chkValid <= strobe.progWr;
      chkStuck <= strobe.progWr && faultHit;
      chkIdx   <= cellIdx;
      chkOld   <= mem[cellIdx];
      chkBit   <= faultBit;
    end
  end

  // R6: a write never turns a 0 into a 1
  assert_only_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |-> ((mem[chkIdx] & ~chkOld) == '0));

  // R10: the faulted bit keeps its 1
  assert_stuck_bit_R10: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && chkStuck && chkOld[chkBit]) |-> mem[chkIdx][chkBit]);

endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_model_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int STORE_AW = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      ceN,
  input  logic                      oeN,
  input  logic                      vppHi,
  input  logic                      a9Hi,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         dataIn,
  output logic [DATA_W-1:0]         dataOut,
  output logic                      dataOe,
  input  logic                      eraseReq,
  output logic                      busy,
  input  logic                      faultEn,
  input  logic [ADDR_W-1:0]         faultAddr,
  input  logic [$clog2(DATA_W)-1:0] faultBit
);

  strobeT              strobe;
  logic [STORE_AW-1:0] eraseIdx;

  eprom_model_ctrl #(.STORE_AW(STORE_AW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .oeN      (oeN),
    .vppHi    (vppHi),
    .a9Hi     (a9Hi),
    .addrLsb  (addr[0]),
    .eraseReq (eraseReq),
    .strobe   (strobe),
    .eraseIdx (eraseIdx),
    .busy     (busy)
  );

  eprom_model_array #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .STORE_AW (STORE_AW)
  ) u_array (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .eraseIdx  (eraseIdx),
    .addr      (addr),
    .dataIn    (dataIn),
    .faultEn   (faultEn),
    .faultAddr (faultAddr),
    .faultBit  (faultBit),
    .dataOut   (dataOut),
    .dataOe    (dataOe)
  );

  // R2: standby or disabled output never drives
  assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!vppHi && (ceN || oeN)) |-> !dataOe);

  // R7: identifier readout
  assert_ident_byte_R7: assert property (@(posedge clk) disable iff (!rstN)
    (a9Hi && !vppHi && !ceN && !oeN && !busy) |->
      (dataOe && (dataOut == (addr[0] ? DATA_W'(8'h04) : DATA_W'(8'h97)))));

  // R8: bus released during the sweep
  assert_erase_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !dataOe);

endmodule

// File: tb/eprom_model_tb.sv
`timescale 1ns/1ps
module eprom_model_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1;
  logic        oeN = 1'b1;
  logic        vppHi = 1'b0;
  logic        a9Hi = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  dataOut;
  logic        dataOe;
  logic        eraseReq = 1'b0;
  logic        busy;
  logic        faultEn = 1'b0;
  logic [14:0] faultAddr = '0;
  logic [2:0]  faultBit = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int busyCnt = 0;

  always #2.5 clk = ~clk;

  eprom_model u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .vppHi(vppHi), .a9Hi(a9Hi),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .eraseReq(eraseReq), .busy(busy), .faultEn(faultEn),
    .faultAddr(faultAddr), .faultBit(faultBit)
  );

  always @(negedge clk) if (busy) busyCnt++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    vppHi = 0; a9Hi = 0; ceN = 1; oeN = 1;
  endtask

  task automatic progByte(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    vppHi = 1; a9Hi = 0; oeN = 1; ceN = 1; addr = a; dataIn = d;
    @(negedge clk); ceN = 0;
    @(negedge clk); ceN = 1;
    @(negedge clk); vppHi = 0;
  endtask

  task automatic readByte(input logic [14:0] a, output logic oe, output logic [7:0] d);
    @(negedge clk);
    vppHi = 0; a9Hi = 0; ceN = 0; oeN = 0; addr = a;
    #1; oe = dataOe; d = dataOut;
  endtask

  task automatic expectByte(input string tag, input logic [14:0] a, input logic [7:0] e);
    logic oe; logic [7:0] d;
    readByte(a, oe, d);
    check({tag, " drive"}, oe, 1);
    check({tag, " data"}, d, e);
  endtask

  task automatic testReset();
    @(negedge clk); #1;
    check("R9 busy after reset", busy, 0);
    check("R2 standby quiet", dataOe, 0);
    expectByte("R9 blank 0x005", 15'h005, 8'hFF);
    expectByte("R9 blank 0x3FF", 15'h3FF, 8'hFF);
  endtask

  task automatic testProgram();
    progByte(15'h010, 8'hA5);
    expectByte("R1 R3 read programmed", 15'h010, 8'hA5);
    progByte(15'h020, 8'h3C);
    progByte(15'h020, 8'hF0);
    expectByte("R6 AND write", 15'h020, 8'h30);
  endtask

  task automatic testVerify();
    @(negedge clk);
    vppHi = 1; ceN = 1; oeN = 0; addr = 15'h010; #1;
    check("R4 verify drive", dataOe, 1);
    check("R4 verify data", dataOut, 8'hA5);
    idle();
  endtask

  task automatic testHeldLow();
    @(negedge clk);
    vppHi = 1; oeN = 1; ceN = 1; addr = 15'h030; dataIn = 8'h0F;
    @(negedge clk); ceN = 0;
    @(negedge clk); dataIn = 8'h00;
    @(negedge clk);
    @(negedge clk); ceN = 1;
    idle();
    expectByte("R3 single write while held low", 15'h030, 8'h0F);
  endtask

  task automatic testInhibit();
    @(negedge clk);
    vppHi = 1; ceN = 1; oeN = 1; addr = 15'h040; dataIn = 8'h00; #1;
    check("R5 inhibit quiet", dataOe, 0);
    repeat (3) @(negedge clk);
    oeN = 0;
    @(negedge clk); ceN = 0; #1;
    check("R5 both low quiet", dataOe, 0);
    repeat (2) @(negedge clk);
    idle();
    expectByte("R5 no write", 15'h040, 8'hFF);
  endtask

  task automatic testOutDisable();
    @(negedge clk);
    vppHi = 0; a9Hi = 0; ceN = 0; oeN = 1; addr = 15'h010; #1;
    check("R2 output disable", dataOe, 0);
    idle();
  endtask

  task automatic testIdent();
    @(negedge clk);
    vppHi = 0; a9Hi = 1; ceN = 0; oeN = 0; addr = 15'h0000; #1;
    check("R7 maker drive", dataOe, 1);
    check("R7 maker byte", dataOut, 8'h97);
    @(negedge clk); addr = 15'h0001; #1;
    check("R7 part byte", dataOut, 8'h04);
    @(negedge clk); addr = 15'h7F01; #1;
    check("R7 upper bits ignored", dataOut, 8'h04);
    @(negedge clk); oeN = 1; #1;
    check("R7 quiet with oeN high", dataOe, 0);
    idle();
  endtask

  task automatic testMirror();
    progByte(15'h0450, 8'h11);
    expectByte("R11 alias read", 15'h050, 8'h11);
    expectByte("R11 alias high read", 15'h7C50, 8'h11);
  endtask

  task automatic testFault();
    @(negedge clk);
    faultEn = 1; faultAddr = 15'h060; faultBit = 3'd3;
    progByte(15'h060, 8'h00);
    expectByte("R10 stuck bit", 15'h060, 8'h08);
    progByte(15'h061, 8'h00);
    expectByte("R10 other address clean", 15'h061, 8'h00);
    @(negedge clk); faultEn = 0;
  endtask

  task automatic testErase();
    logic oe; logic [7:0] d;
    @(negedge clk); busyCnt = 0; eraseReq = 1;
    @(negedge clk); eraseReq = 0;
    check("R8 busy raised", busy, 1);
    progByte(15'h000, 8'h00);
    readByte(15'h010, oe, d);
    check("R8 quiet while busy", oe, 0);
    @(negedge clk); eraseReq = 1;
    @(negedge clk); eraseReq = 0;
    idle();
    while (busy) @(negedge clk);
    check("R8 busy length", busyCnt, 1024);
    repeat (3) @(negedge clk);
    check("R8 stays idle after re-request", busy, 0);
    expectByte("R8 erased 0x010", 15'h010, 8'hFF);
    expectByte("R8 erased 0x020", 15'h020, 8'hFF);
    expectByte("R8 erased 0x060", 15'h060, 8'hFF);
    expectByte("R8 program ignored while busy", 15'h000, 8'hFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    testReset();
    testProgram();
    testVerify();
    testHeldLow();
    testInhibit();
    testOutDisable();
    testIdent();
    testMirror();
    testFault();
    testErase();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule